// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides how deeply a chip sleeps. It runs from an always-on 32 kHz clock, so it keeps working while every faster clock is stopped. It chooses between three operating levels:

- **Awake**: everything runs.
- **Big sleep**: the main PLL is stopped and the 12 MHz oscillator keeps running.
- **Deep sleep**: the oscillator is stopped as well.

The chip drops into big sleep when three subsystems report idle at the same time: a DSP, a host CPU and a transfer controller. From big sleep it goes on to deep sleep once no consumer needs the 12 MHz reference. Two kinds of wake request bring it back:

- **Interrupt wake**: leads to awake.
- **Fast peripheral wake**: restarts the oscillator but parks the chip in big sleep.

Oscillator start-up is modelled by a down-counter. The counter is loaded from a settle-cycle input at the moment the oscillator enable rises. Every control input is passed through a two-stage synchronizer before the state machine sees it. Power-on reset leaves the block in deep sleep and acts as a wake request, so the chip starts up by itself.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `rstN` is low, `pwrState` is 2'b00 (deep sleep), and `oscEn` and `pllEn` are both 0. This holds even if reset is asserted while the chip is awake.
- R2: Reset counts as an interrupt wake. On the first rising edge after `rstN` goes high, `pwrState` becomes 2'b11 (oscillator settling), and the block then proceeds to awake (2'b10) with no input asserted.
- R3: The settling state 2'b11 lasts exactly `settleCycles`+1 clock cycles. The count is the value of `settleCycles` captured on the edge where the oscillator enable rises. A value of 0 gives a single settling cycle.
- R4: Awake changes to big sleep (2'b01) only when `dspIdle`, `hostIdleReq` and `xferIdle` are all 1 and `irqWake` is 0. If any one of the three idle inputs is 0, the block stays awake.
- R5: While awake, a held `irqWake` wins over a met idle condition, and the block stays awake.
- R6: Big sleep changes to deep sleep only when `refClkNeed` is 0 and `hwWake` is 0. Either input held at 1 keeps the block in big sleep.
- R7: An `irqWake` seen in big sleep returns the block to awake directly, with no settling state.
- R8: A `hwWake` seen in deep sleep starts the oscillator (2'b11). After settling, the block enters big sleep, not awake.
- R9: An `irqWake` seen in deep sleep starts the oscillator and then leads to awake. An `irqWake` that is present when a peripheral-triggered settling period ends also leads to awake.
- R10: Output mapping:
  - `pllEn` is 1 only in awake.
  - `oscEn` is 0 only in deep sleep.
  - `pwrState` encodes 00 = deep sleep, 01 = big sleep, 10 = awake, 11 = oscillator settling.
- R11: A change on any control input takes effect on the third rising edge after it. The first two edges belong to the synchronizer and the third to the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk32k | input | 1 | Always-on 32 kHz clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| dspIdle | input | 1 | DSP reports idle (asynchronous) |
| hostIdleReq | input | 1 | Host CPU requests idle (asynchronous) |
| xferIdle | input | 1 | Transfer controller has no outstanding transactions (asynchronous) |
| refClkNeed | input | 1 | 12 MHz reference still required by a pin or a peripheral PLL |
| irqWake | input | 1 | Wake request from the interrupt-based wake logic |
| hwWake | input | 1 | Fast wake request from a peripheral |
| settleCycles | input | CNT_W | Oscillator settling time in clock cycles, quasi-static |
| pllEn | output | 1 | Main PLL enable |
| oscEn | output | 1 | 12 MHz oscillator enable |
| pwrState | output | 2 | Current level: 00 deep, 01 big, 10 awake, 11 settling |

## Verification
The bench targets these corner cases:

- **Idle condition.** Each of the three idle inputs is dropped in turn. A design that checked only part of the condition would fall asleep with a subsystem still busy.
- **Wake priority.** A wake request is held together with a met idle condition. A design with the priority reversed would oscillate between awake and big sleep.
- **Peripheral wake.** The bench confirms that a peripheral wake parks in big sleep, and that a held peripheral wake or reference need blocks deep sleep. A design that got this wrong would starve the USB or UART of its clock.
- **Settling length.** Settling length is measured exactly for counts 0, 2 and 4, where an off-by-one error would show. A reset asserted mid-run proves that reset again forces deep sleep and restarts the chip.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    ST_DEEP       = 3'd0,
    ST_WARM_AWAKE = 3'd1,
    ST_WARM_BIG   = 3'd2,
    ST_BIG        = 3'd3,
    ST_AWAKE      = 3'd4
  } pwrSt_e;

  // Strobes from control to the settle datapath.
  typedef struct packed {
    logic load;   // capture settleCycles, oscillator enable rising
    logic dec;    // count one settling cycle
  } settleStb_t;

  localparam logic [1:0] CODE_DEEP  = 2'b00;
  localparam logic [1:0] CODE_BIG   = 2'b01;
  localparam logic [1:0] CODE_AWAKE = 2'b10;
  localparam logic [1:0] CODE_WARM  = 2'b11;

  // Synchronized input vector bit positions.
  localparam int IN_DSP  = 0;
  localparam int IN_HOST = 1;
  localparam int IN_XFER = 2;
  localparam int IN_NEED = 3;
  localparam int IN_IRQ  = 4;
  localparam int IN_HW   = 5;
  localparam int IN_NUM  = 6;

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    if (gi == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[gi] <= '0;
        else       stageQ[gi] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[gi] <= '0;
        else       stageQ[gi] <= stageQ[gi-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/pwr_settle_dp.sv
module pwr_settle_dp
  import pwr_mode_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  settleStb_t       ctlStb,
  input  logic [CNT_W-1:0] settleCycles,
  output logic             oscStable
);

  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (ctlStb.load) begin
      cntQ <= settleCycles;
    end else if (ctlStb.dec && (cntQ != '0)) begin
      cntQ <= cntQ - 1'b1;
    end
  end

  assign oscStable = (cntQ == '0);

  // R3: the settling count is taken from the input on the load edge
  assert_load_capture_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctlStb.load |=> (cntQ == $past(settleCycles)));

  // R3: a running count never moves upward while settling
  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctlStb.dec && !ctlStb.load) |=> (cntQ <= $past(cntQ)));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [IN_NUM-1:0] inS,
  input  logic              oscStable,
  output settleStb_t        ctlStb,
  output logic              pllEn,
  output logic              oscEn,
  output logic [1:0]        pwrState
);

  pwrSt_e stateQ, stateD;
  logic   rstWakeQ;
  logic   allIdle, irqS, hwS, needS;

  assign allIdle = inS[IN_DSP] & inS[IN_HOST] & inS[IN_XFER];
  assign irqS    = inS[IN_IRQ];
  assign hwS     = inS[IN_HW];
  assign needS   = inS[IN_NEED];

  always_comb begin
    stateD = stateQ;
    ctlStb = '0;
    unique case (stateQ)
      ST_AWAKE: begin
        if (!irqS && allIdle) stateD = ST_BIG;
      end
      ST_BIG: begin
        if (irqS)                stateD = ST_AWAKE;
        else if (!needS && !hwS) stateD = ST_DEEP;
      end
      ST_DEEP: begin
        if (rstWakeQ || irqS) begin
          stateD      = ST_WARM_AWAKE;
          ctlStb.load = 1'b1;
        end else if (hwS) begin
          stateD      = ST_WARM_BIG;
          ctlStb.load = 1'b1;
        end
      end
      ST_WARM_AWAKE: begin
        ctlStb.dec = 1'b1;
        if (oscStable) stateD = ST_AWAKE;
      end
      ST_WARM_BIG: begin
        ctlStb.dec = 1'b1;
        if (oscStable) stateD = irqS ? ST_AWAKE : ST_BIG;
      end
      default: stateD = ST_DEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_DEEP;
      rstWakeQ <= 1'b1;
    end else begin
      stateQ <= stateD;
      if (stateQ == ST_DEEP && stateD != ST_DEEP) rstWakeQ <= 1'b0;
    end
  end

  always_comb begin
    unique case (stateQ)
      ST_DEEP:                    pwrState = CODE_DEEP;
      ST_BIG:                     pwrState = CODE_BIG;
      ST_AWAKE:                   pwrState = CODE_AWAKE;
      ST_WARM_AWAKE, ST_WARM_BIG: pwrState = CODE_WARM;
      default:                    pwrState = CODE_DEEP;
    endcase
  end

  assign pllEn = (stateQ == ST_AWAKE);
  assign oscEn = (stateQ != ST_DEEP);

  // R4, R5: awake may only fall to big sleep on a full idle with no wake
  assert_big_entry_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_AWAKE) |=> ((stateQ != ST_BIG) || $past(allIdle && !irqS)));

  // R6: the reference need or a held peripheral wake blocks deep sleep
  assert_deep_block_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((stateQ == ST_BIG) && (needS || hwS)) |=> (stateQ != ST_DEEP));

  // R3: settling holds until the datapath reports a stable oscillator
  assert_warm_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((pwrState == CODE_WARM) && !oscStable) |=> (pwrState == CODE_WARM));

  // R8, R9: leaving deep sleep always passes through settling
  assert_deep_exit_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == CODE_DEEP) |=> ((pwrState == CODE_DEEP) || (pwrState == CODE_WARM)));

  // R7: an interrupt wake in big sleep reaches awake on the next edge
  assert_big_wake_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((stateQ == ST_BIG) && irqS) |=> (pwrState == CODE_AWAKE));

  // R10: the PLL never runs without the oscillator
  assert_pll_needs_osc_R10: assert property (@(posedge clk) disable iff (!rstN)
    pllEn |-> oscEn);

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk32k,
  input  logic             rstN,
  input  logic             dspIdle,
  input  logic             hostIdleReq,
  input  logic             xferIdle,
  input  logic             refClkNeed,
  input  logic             irqWake,
  input  logic             hwWake,
  input  logic [CNT_W-1:0] settleCycles,
  output logic             pllEn,
  output logic             oscEn,
  output logic [1:0]       pwrState
);

  logic [IN_NUM-1:0] rawIn, inS;
  settleStb_t        ctlStb;
  logic              oscStable;

  always_comb begin
    rawIn          = '0;
    rawIn[IN_DSP]  = dspIdle;
    rawIn[IN_HOST] = hostIdleReq;
    rawIn[IN_XFER] = xferIdle;
    rawIn[IN_NEED] = refClkNeed;
    rawIn[IN_IRQ]  = irqWake;
    rawIn[IN_HW]   = hwWake;
  end

  pwr_sync #(.WIDTH(IN_NUM), .STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk32k),
    .rstN    (rstN),
    .asyncIn (rawIn),
    .syncOut (inS)
  );

  pwr_mode_ctrl ctrl_i (
    .clk       (clk32k),
    .rstN      (rstN),
    .inS       (inS),
    .oscStable (oscStable),
    .ctlStb    (ctlStb),
    .pllEn     (pllEn),
    .oscEn     (oscEn),
    .pwrState  (pwrState)
  );

  pwr_settle_dp #(.CNT_W(CNT_W)) dp_i (
    .clk          (clk32k),
    .rstN         (rstN),
    .ctlStb       (ctlStb),
    .settleCycles (settleCycles),
    .oscStable    (oscStable)
  );

endmodule

// File: tb/pwr_mode_seq_tb_top.sv
module pwr_mode_seq_tb_top;

  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dspIdle = 0, hostIdleReq = 0, xferIdle = 0, refClkNeed = 0, irqWake = 0, hwWake = 0;
  logic [CNT_W-1:0] settleCycles = 16'd4;
  logic pllEn, oscEn;
  logic [1:0] pwrState;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  pwr_mode_seq #(.CNT_W(CNT_W)) dut_i (
    .clk32k(clk), .rstN(rstN), .dspIdle(dspIdle), .hostIdleReq(hostIdleReq),
    .xferIdle(xferIdle), .refClkNeed(refClkNeed), .irqWake(irqWake), .hwWake(hwWake),
    .settleCycles(settleCycles), .pllEn(pllEn), .oscEn(oscEn), .pwrState(pwrState)
  );

  // Entry: {req[3:0], inputs {dsp,host,xfer,need,irq,hw}, wait[5:0], expState[1:0]}
  // State codes: 00 deep, 01 big, 10 awake, 11 settling (settleCycles = 4).
  localparam int NVEC = 21;
  localparam logic [17:0] VEC [NVEC] = '{
    {4'd4,  6'b111100, 6'd4, 2'b01},  // R4 all idle -> big
    {4'd6,  6'b111100, 6'd6, 2'b01},  // R6 need held keeps big
    {4'd7,  6'b111110, 6'd4, 2'b10},  // R7 irq in big -> awake
    {4'd5,  6'b111110, 6'd6, 2'b10},  // R5 irq beats idle
    {4'd4,  6'b111100, 6'd4, 2'b01},  // R4 irq gone -> big
    {4'd6,  6'b111000, 6'd4, 2'b00},  // R6 need low -> deep
    {4'd8,  6'b000000, 6'd6, 2'b00},  // R8 no wake stays deep
    {4'd11, 6'b000001, 6'd3, 2'b11},  // R11 hw acts on third edge
    {4'd8,  6'b000001, 6'd5, 2'b01},  // R8 hw settles in big
    {4'd6,  6'b000001, 6'd6, 2'b01},  // R6 held hw blocks deep
    {4'd6,  6'b000000, 6'd4, 2'b00},  // R6 hw gone -> deep
    {4'd11, 6'b000010, 6'd3, 2'b11},  // R11 irq acts on third edge
    {4'd9,  6'b000010, 6'd5, 2'b10},  // R9 irq settles to awake
    {4'd4,  6'b110000, 6'd6, 2'b10},  // R4 xfer busy
    {4'd4,  6'b011000, 6'd6, 2'b10},  // R4 dsp busy
    {4'd4,  6'b101000, 6'd6, 2'b10},  // R4 host not idle
    {4'd4,  6'b111000, 6'd3, 2'b01},  // R4 full idle -> big
    {4'd6,  6'b111000, 6'd1, 2'b00},  // R6 next edge -> deep
    {4'd8,  6'b111001, 6'd3, 2'b11},  // R8 hw from deep
    {4'd9,  6'b111011, 6'd5, 2'b10},  // R9 irq during hw settle -> awake
    {4'd5,  6'b000000, 6'd4, 2'b10}   // R5 quiet awake stays awake
  };

  task automatic checkOut(input logic [1:0] expState, input string req);
    logic expPll, expOsc;
    expPll = (expState == 2'b10);
    expOsc = (expState != 2'b00);
    nChecks++;
    if (pwrState !== expState || pllEn !== expPll || oscEn !== expOsc) begin
      nFails++;
      $display("FAIL %s: state=%b pll=%b osc=%b expected state=%b pll=%b osc=%b",
               req, pwrState, pllEn, oscEn, expState, expPll, expOsc);
    end
  endtask

  task automatic setIn(input logic [5:0] v);
    {dspIdle, hostIdleReq, xferIdle, refClkNeed, irqWake, hwWake} = v;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkOut(2'b00, "R1 in reset");
    rstN = 1'b1;
    edges(1); checkOut(2'b11, "R2 reset wakes");
    edges(9); checkOut(2'b10, "R2 awake after reset");

    for (int k = 0; k < NVEC; k++) begin
      setIn(VEC[k][13:8]);
      edges(int'(VEC[k][7:2]));
      checkOut(VEC[k][1:0], $sformatf("R%0d vector %0d", VEC[k][17:14], k));
    end

    // R1 reset while awake, then R3 settle length with count 2
    settleCycles = 16'd2;
    rstN = 1'b0;
    #1; checkOut(2'b00, "R1 reset while awake");
    @(negedge clk); rstN = 1'b1;
    edges(1); checkOut(2'b11, "R3 settle edge1");
    edges(2); checkOut(2'b11, "R3 settle edge3");
    edges(1); checkOut(2'b10, "R3 awake after 3 cycles");

    // R3 zero count gives one settling cycle
    settleCycles = 16'd0;
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    edges(1); checkOut(2'b11, "R3 zero settle edge1");
    edges(1); checkOut(2'b10, "R3 zero settle awake");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule